// File: doc/BRIEF.md
# Selectable User Clock Generator

This block produces one peripheral clock from a choice of eight candidate clocks. A glitch-free selector picks one of seven shared clock nets or a dedicated routed input. A programmable 16-bit divider follows the selector. An optional retime stage can then realign the divided clock to the master clock. In analog mode this stage uses a phase-shifted copy of the master clock instead.

Software changes the source select and the divide value while the clock runs. The block hands over between sources and between divide values without producing short pulses. Sync enable and analog mode are static settings. They may be changed only while the enable is low.

Top module: `ucg_user_clk`

## Requirements
- R1: The selection code picks the clock input: 0 master, 1 main oscillator, 2 crystal, 3 low-speed oscillator, 4 PLL, 5 32.768 kHz, 6 global routed clock, 7 dedicated routed input. The output period scales with the period of the chosen input.
- R2: The divide value holds N-1. A value of 0 passes the chosen clock through unchanged. Any other value D gives a period of D+1 source cycles, and D = 65535 divides by 65536.
- R3: For N of 2 or more, the output is high for floor(N/2) source cycles and low for the rest of the period, starting with the high phase.
- R4: With sync enable low, output edges follow the source edges directly. With sync enable high and analog mode low, every output edge falls on a rising edge of the master clock, and the skewed master input has no effect.
- R5: With sync enable and analog mode both high, every output edge falls on a rising edge of the skewed master clock.
- R6: A new divide value takes effect only at the terminal count of the current period. The period in progress completes at its old length.
- R7: While the enable is low, the output is held low and the counter is preset to its terminal count. After the enable returns high, the first pulse appears within two source cycles and has the full high width.
- R8: Changing the source select at runtime never produces an output pulse shorter than the shortest half period of the clocks involved. No more than one source is gated through at any time.
- R9: While the active-low reset is asserted, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_master_i | input | 1 | Master clock; source 0 and the digital retime clock |
| clk_master_skew_i | input | 1 | Phase-shifted master clock for analog retime |
| clk_main_osc_i | input | 1 | Source 1 |
| clk_xtal_i | input | 1 | Source 2 |
| clk_slow_osc_i | input | 1 | Source 3 |
| clk_pll_i | input | 1 | Source 4 |
| clk_32k_i | input | 1 | Source 5 |
| clk_glb_route_i | input | 1 | Source 6 |
| clk_route_i | input | 1 | Source 7, dedicated routed input |
| sel_i | input | 3 | Source selection code |
| div_i | input | DIV_W | Divide value minus one |
| sync_en_i | input | 1 | Retime the divided clock |
| analog_i | input | 1 | Retime on the skewed master instead of the master |
| en_i | input | 1 | Output enable |
| clk_o | output | 1 | Generated clock |

## Verification
The bench records edge timestamps on the output, so it can see how the block shapes the clock as well as that it toggles. It checks the period, the high time and the edge phase against the master grid. A swapped selector code gives a wrong period, and an off-by-one in the N-1 encoding or the duty split gives a wrong period or high time. A retime stage wired to the wrong clock puts the edges at the wrong phase. One check stretches a running period and changes the divide value mid-period: a design that reloads early cuts that period short. A disable-and-restart check catches a counter that is not preset, because the first pulse then comes out short. A pulse-width monitor runs through every live source change and flags any runt the handover leaves.

// File: rtl/ucg_pkg.sv
`timescale 1ns/1ps
package ucg_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned SEL_W   = $clog2(NUM_SRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_MASTER   = 3'd0,
    SRC_MAIN_OSC = 3'd1,
    SRC_XTAL     = 3'd2,
    SRC_SLOW_OSC = 3'd3,
    SRC_PLL      = 3'd4,
    SRC_32K      = 3'd5,
    SRC_GLB      = 3'd6,
    SRC_ROUTE    = 3'd7
  } src_e;
endpackage

// File: rtl/ucg_src_mux.sv
`timescale 1ns/1ps
module ucg_src_mux #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  clk_src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o,
  output logic [NSRC-1:0]  on_o
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_leg
    logic arm_q, on_q, others;
    // a leg may arm only once every other leg has released
    assign others = |(on_o & ~(NSRC'(1) << i));

    always_ff @(posedge clk_src_i[i] or negedge rst_ni)
      if (!rst_ni) arm_q <= 1'b0;
      else         arm_q <= (sel_i == SEL_W'(i)) && !others;

    // enable changes only while this source is low
    always_ff @(negedge clk_src_i[i] or negedge rst_ni)
      if (!rst_ni) on_q <= 1'b0;
      else         on_q <= arm_q;

    assign on_o[i]  = on_q;
    assign gated[i] = clk_src_i[i] & on_q;
  end

  assign clk_o = |gated;
endmodule

// File: rtl/ucg_divider.sv
`timescale 1ns/1ps
module ucg_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             rst_ni,
  input  logic             clk_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o,
  output logic             en_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, div_q;
  logic             q, en_q, en_n;

  function automatic logic [HW-1:0] half_of(input logic [DIV_W-1:0] d);
    return ({1'b0, d} + HW'(1)) >> 1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      div_q <= '0;
      q     <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_q) begin
        // preset to terminal so restart begins with a full high phase
        cnt_q <= div_i;
        div_q <= div_i;
        q     <= 1'b0;
      end else if (cnt_q == div_q) begin
        cnt_q <= '0;
        div_q <= div_i;
        q     <= (half_of(div_i) != '0);
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
        q     <= ({1'b0, cnt_q} + HW'(1)) < half_of(div_q);
      end
    end

  // bypass gate moves only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) en_n <= 1'b0;
    else         en_n <= en_q;

  assign clk_o = (div_q == '0) ? (clk_i & en_n) : q;
  assign en_o  = en_q;
  assign cnt_o = cnt_q;
  assign div_o = div_q;
endmodule

// File: rtl/ucg_retime.sv
`timescale 1ns/1ps
module ucg_retime (
  input  logic rst_ni,
  input  logic clk_m_i,
  input  logic clk_s_i,
  input  logic d_i,
  input  logic sync_i,
  input  logic analog_i,
  output logic clk_o
);
  logic r_m, r_s;

  always_ff @(posedge clk_m_i or negedge rst_ni)
    if (!rst_ni) r_m <= 1'b0;
    else         r_m <= d_i;

  always_ff @(posedge clk_s_i or negedge rst_ni)
    if (!rst_ni) r_s <= 1'b0;
    else         r_s <= d_i;

  // path select is static; change only while disabled
  assign clk_o = !sync_i ? d_i : (analog_i ? r_s : r_m);
endmodule

// File: rtl/ucg_user_clk.sv
`timescale 1ns/1ps
module ucg_user_clk
  import ucg_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             rst_ni,
  input  logic             clk_master_i,
  input  logic             clk_master_skew_i,
  input  logic             clk_main_osc_i,
  input  logic             clk_xtal_i,
  input  logic             clk_slow_osc_i,
  input  logic             clk_pll_i,
  input  logic             clk_32k_i,
  input  logic             clk_glb_route_i,
  input  logic             clk_route_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sync_en_i,
  input  logic             analog_i,
  input  logic             en_i,
  output logic             clk_o
);
  logic [NUM_SRC-1:0] src, src_on;
  logic               mux_clk, div_clk, div_en;
  logic [DIV_W-1:0]   div_cnt, div_act;

  always_comb begin
    src               = '0;
    src[SRC_MASTER]   = clk_master_i;
    src[SRC_MAIN_OSC] = clk_main_osc_i;
    src[SRC_XTAL]     = clk_xtal_i;
    src[SRC_SLOW_OSC] = clk_slow_osc_i;
    src[SRC_PLL]      = clk_pll_i;
    src[SRC_32K]      = clk_32k_i;
    src[SRC_GLB]      = clk_glb_route_i;
    src[SRC_ROUTE]    = clk_route_i;
  end

  ucg_src_mux #(.NSRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .rst_ni(rst_ni), .clk_src_i(src), .sel_i(sel_i),
    .clk_o(mux_clk), .on_o(src_on)
  );

  ucg_divider #(.DIV_W(DIV_W)) u_div (
    .rst_ni(rst_ni), .clk_i(mux_clk), .en_i(en_i), .div_i(div_i),
    .clk_o(div_clk), .en_o(div_en), .cnt_o(div_cnt), .div_o(div_act)
  );

  ucg_retime u_rt (
    .rst_ni(rst_ni), .clk_m_i(clk_master_i), .clk_s_i(clk_master_skew_i),
    .d_i(div_clk), .sync_i(sync_en_i), .analog_i(analog_i), .clk_o(clk_o)
  );
endmodule

// File: rtl/ucg_user_clk_chk.sv
`timescale 1ns/1ps
module ucg_user_clk_chk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned NSRC  = 8
) (
  input logic             rst_ni,
  input logic             clk_master_i,
  input logic             clk_master_skew_i,
  input logic             sync_en_i,
  input logic             analog_i,
  input logic             clk_o,
  input logic             mux_clk,
  input logic [NSRC-1:0]  src_on,
  input logic             div_clk,
  input logic             div_en,
  input logic [DIV_W-1:0] div_cnt,
  input logic [DIV_W-1:0] div_act
);
  AST_ONE_SRC: assert property (@(posedge clk_master_i) disable iff (!rst_ni)
    $onehot0(src_on)); // R8

  AST_CNT_BOUND: assert property (@(posedge mux_clk) disable iff (!rst_ni)
    div_cnt <= div_act); // R2

  AST_TC_WRAP: assert property (@(posedge mux_clk) disable iff (!rst_ni)
    (div_en && div_cnt == div_act) |=> (div_cnt == '0)); // R6

  AST_DIV_HOLD: assert property (@(posedge mux_clk) disable iff (!rst_ni)
    (div_en && div_cnt != div_act) |=> $stable(div_act)); // R6

  AST_DIS_PRESET: assert property (@(posedge mux_clk) disable iff (!rst_ni)
    !div_en |=> (div_cnt == div_act)); // R7

  AST_SYNC_DIG: assert property (@(posedge clk_master_i) disable iff (!rst_ni)
    (sync_en_i && !analog_i && $past(sync_en_i) && !$past(analog_i))
      |-> (clk_o == $past(div_clk))); // R4

  AST_SYNC_ANA: assert property (@(posedge clk_master_skew_i) disable iff (!rst_ni)
    (sync_en_i && analog_i && $past(sync_en_i) && $past(analog_i))
      |-> (clk_o == $past(div_clk))); // R5
endmodule

bind ucg_user_clk ucg_user_clk_chk #(.DIV_W(DIV_W), .NSRC(ucg_pkg::NUM_SRC)) u_chk (
  .rst_ni(rst_ni), .clk_master_i(clk_master_i), .clk_master_skew_i(clk_master_skew_i),
  .sync_en_i(sync_en_i), .analog_i(analog_i), .clk_o(clk_o),
  .mux_clk(mux_clk), .src_on(src_on), .div_clk(div_clk), .div_en(div_en),
  .div_cnt(div_cnt), .div_act(div_act)
);

// File: tb/sim_ucg_user_clk.sv
`timescale 1ns/1ps
module sim_ucg_user_clk;
  localparam int unsigned DIV_W = 16;
  localparam int unsigned ROWS  = 9;
  // {sel, div, sync, analog}
  localparam logic [20:0] VEC [ROWS] = '{
    {3'd1, 16'd0, 1'b0, 1'b0},
    {3'd1, 16'd1, 1'b0, 1'b0},
    {3'd2, 16'd2, 1'b0, 1'b0},
    {3'd0, 16'd4, 1'b0, 1'b0},
    {3'd3, 16'd3, 1'b1, 1'b0},
    {3'd4, 16'd6, 1'b1, 1'b1},
    {3'd7, 16'd1, 1'b1, 1'b0},
    {3'd5, 16'd2, 1'b0, 1'b0},
    {3'd6, 16'd0, 1'b1, 1'b1}
  };

  logic rst_ni = 1'b0;
  logic mclk = 1'b0, skew = 1'b0, skew_run = 1'b1;
  logic [7:1] s = '0;
  logic [2:0] sel = 3'd1;
  logic [DIV_W-1:0] div = '0;
  logic syn = 1'b0, an = 1'b0, en = 1'b1;
  logic clk_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // 250 MHz master, rising edges at 2 mod 4 ns
  initial forever #2 mclk = ~mclk;
  initial begin #1; forever begin #2; if (skew_run) skew = ~skew; end end
  for (genvar k = 1; k < 8; k++) begin : g_src
    initial begin #1; forever #(4 * k) s[k] = ~s[k]; end
  end

  ucg_user_clk #(.DIV_W(DIV_W)) u0 (
    .rst_ni(rst_ni), .clk_master_i(mclk), .clk_master_skew_i(skew),
    .clk_main_osc_i(s[1]), .clk_xtal_i(s[2]), .clk_slow_osc_i(s[3]),
    .clk_pll_i(s[4]), .clk_32k_i(s[5]), .clk_glb_route_i(s[6]),
    .clk_route_i(s[7]), .sel_i(sel), .div_i(div), .sync_en_i(syn),
    .analog_i(an), .en_i(en), .clk_o(clk_o)
  );

  // pulse-width monitor
  bit  mon_on = 1'b0, have_last = 1'b0;
  real last_t = 0.0, min_w = 1.0e9;
  always @(clk_o) if (mon_on) begin
    if (have_last && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime; have_last = 1'b1;
  end

  task automatic chk(input string req, input real act, input real exp);
    checks++;
    if (act > exp + 0.001 || act < exp - 0.001) begin
      errors++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic at_safe();
    @(negedge mclk); #0.5;
  endtask

  task automatic measure(output real per, output real hi, output real ph);
    real t0, t1, t2;
    @(posedge clk_o); t0 = $realtime;
    @(negedge clk_o); t1 = $realtime;
    @(posedge clk_o); t2 = $realtime;
    per = t2 - t0; hi = t1 - t0;
    ph = real'(longint'(t0 * 1000.0) % 64'sd4000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #760000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    real per, hi, ph, t_en, t0, t1;
    #10;
    chk("R9 reset output low", real'(clk_o), 0.0);
    #10 rst_ni = 1'b1;
    #200;
    mon_on = 1'b1;

    for (int i = 0; i < int'(ROWS); i++) begin
      logic [2:0] v_sel; logic [15:0] v_div; logic v_syn, v_an;
      real tsrc, n, exp_p, exp_h, exp_ph;
      {v_sel, v_div, v_syn, v_an} = VEC[i];
      if (v_syn != syn || v_an != an) begin
        at_safe(); en = 1'b0;
        #200;
        at_safe(); sel = v_sel; div = v_div; syn = v_syn; an = v_an;
        at_safe(); en = 1'b1;
      end else begin
        at_safe(); sel = v_sel; div = v_div;
      end
      skew_run = !(v_syn && !v_an); // R4: digital retime must not need the skewed clock
      #3000;
      measure(per, hi, ph);
      tsrc   = (v_sel == 3'd0) ? 4.0 : 8.0 * real'(v_sel);
      n      = real'(v_div) + 1.0;
      exp_p  = n * tsrc;
      exp_h  = (v_div == '0) ? tsrc / 2.0 : real'((int'(v_div) + 1) / 2) * tsrc;
      exp_ph = v_syn ? (v_an ? 3000.0 : 2000.0) : ((v_sel == 3'd0) ? 2000.0 : 1000.0);
      chk($sformatf("R1 R2 period row %0d", i), per, exp_p);
      chk($sformatf("R3 high row %0d", i), hi, exp_h);
      chk($sformatf("R4 R5 edge phase row %0d", i), ph, exp_ph);
    end
    skew_run = 1'b1;

    // R6: divide change waits for terminal count
    at_safe(); en = 1'b0;
    #200;
    at_safe(); sel = 3'd1; div = 16'd9; syn = 1'b0; an = 1'b0;
    at_safe(); en = 1'b1;
    #1000;
    @(posedge clk_o); t0 = $realtime;
    #0.5 div = 16'd1;
    @(posedge clk_o); t1 = $realtime;
    chk("R6 old period completes", t1 - t0, 80.0);
    measure(per, hi, ph);
    chk("R6 new period", per, 16.0);

    // R7: disable holds low, restart full pulse
    at_safe(); div = 16'd3;
    #500;
    at_safe(); en = 1'b0;
    #100;
    begin
      int highs = 0;
      for (int k = 0; k < 40; k++) begin #3; if (clk_o) highs++; end
      chk("R7 output low while disabled", real'(highs), 0.0);
    end
    at_safe(); en = 1'b1; t_en = $realtime;
    @(posedge clk_o); t0 = $realtime;
    @(negedge clk_o); t1 = $realtime;
    chk("R7 restart within two source cycles", (t0 - t_en <= 17.0) ? 1.0 : 0.0, 1.0);
    chk("R7 restart full high width", t1 - t0, 16.0);

    // R2: largest divide value
    at_safe(); en = 1'b0;
    #100;
    at_safe(); div = 16'hFFFF;
    at_safe(); en = 1'b1;
    @(posedge clk_o); t0 = $realtime;
    @(negedge clk_o); t1 = $realtime;
    chk("R2 R3 divide by 65536 high width", t1 - t0, 262144.0);
    at_safe(); en = 1'b0;
    #100;

    chk("R8 no runt pulse during switching", (min_w >= 3.999) ? 1.0 : 0.0, 1.0);
    finish_run();
  end
endmodule